// File: doc/BRIEF.md
# Single-wire bus master slot engine

This block drives a single-wire open-drain bus as the master at standard speed. It produces the low pulses that form a bus reset, a one-bit write and a one-bit read. Each operation runs in one time slot, and the block reads the bus back at fixed points in that slot. All timing comes from a one-microsecond tick input, so the system clock can be any rate faster than that tick.

A host starts one operation at a time. It holds `req_valid` high for a cycle with an operation code and, for a write, the data bit. While the slot runs, `busy` stays high and `pull_low` enables the external pulldown. When the whole slot or reset period has elapsed, `done` pulses for one clock. The host then reads `present` after a reset, or `rd_bit` after a read. Grouping bits into bytes and running a device search are left to the host.

Top module: `sw_slot_master`

## Requirements
- R1: After reset, `pull_low`, `busy`, `done`, `present` and `rd_bit` are all 0.
- R2: A reset operation (`req_op` = 0) holds `pull_low` high for exactly `RST_LOW_US` ticks (default 480), starting in the cycle the request is accepted.
- R3: A reset operation samples `bus_in` on tick `RST_LOW_US + PRES_SAMPLE_US` (default 550) counted from the start. `present` becomes 1 if the bus was low at that sample and 0 otherwise, and it is cleared when a reset operation is accepted.
- R4: A reset operation keeps `busy` high for `RST_LOW_US + RST_HIGH_US` ticks (default 960), so the line stays released for at least 480 µs before the next request can be accepted.
- R5: A write operation (`req_op` = 1) holds `pull_low` for `W0_LOW_US` ticks (65) when `req_bit` = 0, or for `W1_LOW_US` ticks (6) when `req_bit` = 1. It keeps `busy` high for `SLOT_US` ticks (70).
- R6: A read operation (`req_op` = 2) holds `pull_low` for `RD_LOW_US` ticks (6). It loads `rd_bit` with `bus_in` on tick `RD_SAMPLE_US` (13) of the slot and keeps `busy` high for `SLOT_US` ticks.
- R7: `done` is high for exactly one clock, in the cycle in which `busy` first reads 0 after an operation.
- R8: A request made while `busy` is high has no effect on the running slot or on `present` and `rd_bit`. A request with `req_op` = 3 is never accepted.
- R9: Slot timing advances only on clocks where `tick_us` is high. With no tick, `pull_low` and `busy` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-clock pulse each microsecond |
| req_valid | input | 1 | Request strobe, accepted only when idle |
| req_op | input | 2 | 0 reset, 1 write, 2 read, 3 reserved |
| req_bit | input | 1 | Data bit for a write |
| bus_in | input | 1 | Sampled bus level (1 = high) |
| pull_low | output | 1 | Enable for the open-drain pulldown |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-clock pulse when an operation ends |
| rd_bit | output | 1 | Bit captured by the last read |
| present | output | 1 | Slave answered the last reset |

## Verification
If the microsecond counter or the latched operation goes wrong, the fault reaches the ports within one tick. `pull_low` then drops at the wrong microsecond, or `busy` and `done` end the slot early or late. The bench's per-clock model catches either on the first clock it differs. If a sample is taken at the wrong time, the bench's slave no longer pulls the bus low at the sample point, so `present` or `rd_bit` reads wrong. That shows at the clock just after the sampling tick and stays visible until the next operation of the same kind.

// File: rtl/sw_slot_master.sv
`timescale 1ns/1ps
module sw_slot_master #(
  parameter int RST_LOW_US     = 480,
  parameter int PRES_SAMPLE_US = 70,
  parameter int RST_HIGH_US    = 480,
  parameter int W0_LOW_US      = 65,
  parameter int W1_LOW_US      = 6,
  parameter int RD_LOW_US      = 6,
  parameter int RD_SAMPLE_US   = 13,
  parameter int SLOT_US        = 70
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       req_valid,
  input  logic [1:0] req_op,
  input  logic       req_bit,
  input  logic       bus_in,
  output logic       pull_low,
  output logic       busy,
  output logic       done,
  output logic       rd_bit,
  output logic       present
);

  localparam int RST_TOTAL = RST_LOW_US + RST_HIGH_US;
  localparam int RST_SMP   = RST_LOW_US + PRES_SAMPLE_US;
  localparam int CW        = $clog2(RST_TOTAL + 1);
  localparam logic [1:0] OP_RST = 2'd0;
  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_RD  = 2'd2;
  localparam logic [1:0] OP_NONE = 2'd3;

  logic          busy_q, done_q, rd_q, pres_q, bit_q;
  logic [1:0]    op_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] low_len, total_len, smp_at;
  logic          accept, smp_hit, last_tick;

  always_comb begin
    low_len   = CW'(RD_LOW_US);
    total_len = CW'(SLOT_US);
    smp_at    = CW'(RD_SAMPLE_US);
    case (op_q)
      OP_RST: begin
        low_len   = CW'(RST_LOW_US);
        total_len = CW'(RST_TOTAL);
        smp_at    = CW'(RST_SMP);
      end
      OP_WR: begin
        low_len = bit_q ? CW'(W1_LOW_US) : CW'(W0_LOW_US);
        smp_at  = CW'(RST_TOTAL);
      end
      default: ;
    endcase
  end

  assign accept    = req_valid && !busy_q && (req_op != OP_NONE);
  assign smp_hit   = busy_q && tick_us && (cnt == smp_at);
  assign last_tick = busy_q && tick_us && (cnt == total_len - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= OP_RST;
      bit_q  <= 1'b0;
      cnt    <= '0;
    end else begin
      done_q <= last_tick;
      if (busy_q) begin
        if (tick_us) cnt <= cnt + CW'(1);
        if (last_tick) busy_q <= 1'b0;
      end else if (accept) begin
        busy_q <= 1'b1;
        op_q   <= req_op;
        bit_q  <= req_bit;
        cnt    <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      pres_q <= 1'b0;
    end else begin
      if (accept && req_op == OP_RST) pres_q <= 1'b0;
      else if (smp_hit && op_q == OP_RST) pres_q <= !bus_in;
      if (smp_hit && op_q == OP_RD) rd_q <= bus_in;
    end
  end

  assign pull_low = busy_q && (cnt < low_len);
  assign busy     = busy_q;
  assign done     = done_q;
  assign rd_bit   = rd_q;
  assign present  = pres_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  // R8
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (!busy_q || $stable(op_q)));

  // R9
  no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick_us) |=> (busy_q && $stable(cnt)));

  // R2
  rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pull_low) && busy_q && op_q == OP_RST) |-> (cnt == CW'(RST_LOW_US)));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt < total_len));

endmodule

// File: tb/sim_sw_slot_master.sv
`timescale 1ns/1ps
module sim_sw_slot_master;
  localparam int DIV = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_us = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic       req_bit = 1'b0;
  logic       bus_in;
  logic       pull_low, busy, done, rd_bit, present;

  logic tick_run = 1'b1;
  logic slave_on = 1'b0;
  logic slave_bit = 1'b1;
  logic slave_pull;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int divc = 0;
  int low_ticks = 0;

  int e_busy = 0, e_us = 0, e_op = 0, e_bit = 0, e_done = 0, e_pres = 0, e_rd = 0;
  int e_low, e_total;

  always #10 clk = ~clk;

  sw_slot_master u0 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .req_valid(req_valid),
    .req_op(req_op), .req_bit(req_bit), .bus_in(bus_in), .pull_low(pull_low),
    .busy(busy), .done(done), .rd_bit(rd_bit), .present(present)
  );

  assign slave_pull = slave_on && e_busy != 0 &&
    ((e_op == 0 && e_us >= 500 && e_us < 600) ||
     (e_op == 2 && e_us >= 1 && e_us < 30 && !slave_bit));
  assign bus_in = !(pull_low || slave_pull);

  always_comb begin
    e_low = (e_op == 0) ? 480 : (e_op == 1) ? (e_bit != 0 ? 6 : 65) : 6;
    e_total = (e_op == 0) ? 960 : 70;
  end

  always @(negedge clk) begin
    if (tick_run) begin
      divc = (divc + 1) % DIV;
      tick_us <= (divc == 0);
    end else tick_us <= 1'b0;
  end

  always @(posedge clk) begin
    if (tick_us && pull_low) low_ticks = low_ticks + 1;
    if (!rst_n) begin
      e_busy = 0; e_done = 0; e_pres = 0; e_rd = 0; e_us = 0;
    end else begin
      e_done = 0;
      if (e_busy != 0) begin
        if (tick_us) begin
          if (e_op == 0 && e_us == 550) e_pres = bus_in ? 0 : 1;
          if (e_op == 2 && e_us == 13) e_rd = bus_in ? 1 : 0;
          e_us = e_us + 1;
          if (e_us == e_total) begin e_busy = 0; e_done = 1; end
        end
      end else if (req_valid && req_op != 2'd3) begin
        e_busy = 1; e_us = 0; e_op = req_op; e_bit = req_bit;
        if (req_op == 2'd0) e_pres = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic string op_tag();
    return (e_op == 0) ? "R2" : (e_op == 1) ? "R5" : "R6";
  endfunction

  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst_n) begin
      chk(pull_low == (e_busy != 0 && e_us < e_low), op_tag(), pull_low,
          (e_busy != 0 && e_us < e_low) ? 1 : 0);
      chk(busy == (e_busy != 0), (e_op == 0) ? "R4" : "R5,R6", busy, e_busy);
      chk(done == (e_done != 0), "R7", done, e_done);
      chk(present == (e_pres != 0), "R3", present, e_pres);
      chk(rd_bit == (e_rd != 0), "R6", rd_bit, e_rd);
    end
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_op(input int op, input bit b);
    @(negedge clk);
    low_ticks = 0;
    req_valid = 1'b1; req_op = 2'(op); req_bit = b;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!pull_low && !busy && !done && !present && !rd_bit, "R1",
        {pull_low, busy, done, present, rd_bit}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pull_low && !busy, "R1", {pull_low, busy}, 0);

    slave_on = 1'b1;
    run_op(0, 1'b0);
    chk(low_ticks == 480, "R2", low_ticks, 480);
    @(negedge clk);
    chk(present == 1'b1, "R3", present, 1);
    chk(done == 1'b0, "R7", done, 0);

    slave_on = 1'b0;
    run_op(0, 1'b0);
    @(negedge clk);
    chk(present == 1'b0, "R3", present, 0);
    slave_on = 1'b1;
    run_op(0, 1'b0);
    @(negedge clk);
    chk(present == 1'b1, "R3", present, 1);

    run_op(1, 1'b0);
    chk(low_ticks == 65, "R5", low_ticks, 65);
    run_op(1, 1'b1);
    chk(low_ticks == 6, "R5", low_ticks, 6);

    slave_bit = 1'b0;
    run_op(2, 1'b0);
    chk(low_ticks == 6, "R6", low_ticks, 6);
    @(negedge clk);
    chk(rd_bit == 1'b0, "R6", rd_bit, 0);
    slave_bit = 1'b1;
    run_op(2, 1'b0);
    @(negedge clk);
    chk(rd_bit == 1'b1, "R6", rd_bit, 1);

    @(negedge clk);
    low_ticks = 0;
    req_valid = 1'b1; req_op = 2'd1; req_bit = 1'b1;
    @(negedge clk);
    req_op = 2'd0; req_bit = 1'b0;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(low_ticks == 6, "R8", low_ticks, 6);
    chk(present == 1'b1, "R8", present, 1);

    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd3;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b0 && pull_low == 1'b0, "R8", {busy, pull_low}, 0);

    @(negedge clk);
    low_ticks = 0;
    req_valid = 1'b1; req_op = 2'd1; req_bit = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (30) @(negedge clk);
    tick_run = 1'b0;
    repeat (2) @(negedge clk);
    begin
      logic p0;
      p0 = pull_low;
      repeat (100) @(negedge clk);
      chk(pull_low == p0 && busy == 1'b1, "R9", {pull_low, busy}, {p0, 1'b1});
    end
    tick_run = 1'b1;
    while (!done) @(negedge clk);
    chk(low_ticks == 65, "R9", low_ticks, 65);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule